// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block links two parallel buses, A and B, and holds one storage register per direction. The A-side register samples the A bus and can be sent toward B. The B-side register samples the B bus and can be sent toward A. For each direction, a path select chooses between the live value of the opposite bus and the stored word. A per-direction enable decides whether that side drives its pins.

The bidirectional pins are split into an input vector, an output vector and an output-enable vector per bus. The enable vector repeats the direction enable on every bit, and the output vector is always defined. Whenever a side is driving, the bus value seen inside the block is the block's own output. Otherwise it is the external input. As a result, a driven bus can be looped back so that one bus's word ends up in both registers.

The block runs on one clock. The two load strobes are sampled as ordinary inputs, and a load takes place on a detected low-to-high change of a strobe.

Top module: `bus_xcvr_reg`

## Requirements
- R1: `b_oe_o` is all ones while `ab_en_i` is 1 and all zeros while it is 0 (active-high A-to-B enable).
- R2: `a_oe_o` is all ones while `ba_en_ni` is 0 and all zeros while it is 1 (active-low B-to-A enable).
- R3: With `ab_en_i`=0 and `ba_en_ni`=1 neither side drives, and `a_o`/`b_o` still carry their path values.
- R4: A select of 0 (`ab_sel_i` for B, `ba_sel_i` for A) passes the live opposite bus. A select of 1 passes the stored register of the opposite side.
- R5: At a clock edge where a strobe is 1 and was 0 at the previous edge, its register loads the current bus value. This happens regardless of enables and selects. A strobe held high loads only once, and a low strobe holds the register.
- R6: The bus value used by the registers and live paths is the block's own output on a driven side and the external input otherwise. With A-to-B live and both strobes raised, the A word lands in both registers.
- R7: `rst_ni` low asynchronously clears both registers and both strobe histories. A strobe already high when reset is released counts as a rising change at the first edge.
- R8: Loads on both strobes at the same edge capture the bus values present before that edge, including a stored word that is being driven across.
- R9: With both sides driving and both selects live, `a_o` equals `b_i` and `b_o` equals `a_i`, and each register loads its own external input.
- R10: When the live value equals the stored value, changing a select leaves the affected output unchanged. The selector carries a consensus term for this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ab_en_i | input | 1 | A-to-B drive enable, active high |
| ba_en_ni | input | 1 | B-to-A drive enable, active low |
| ab_sel_i | input | 1 | B output path: 0 live A, 1 stored A |
| ba_sel_i | input | 1 | A output path: 0 live B, 1 stored B |
| ab_ld_i | input | 1 | A register load strobe |
| ba_ld_i | input | 1 | B register load strobe |
| a_i | input | W | A pins, input value |
| a_o | output | W | A pins, output value |
| a_oe_o | output | W | A pins, output enable per bit |
| b_i | input | W | B pins, input value |
| b_o | output | W | B pins, output value |
| b_oe_o | output | W | B pins, output enable per bit |

## Verification
The bench builds the block with W=8, the default. Eight bits are enough to make every register, loopback and contention word distinct from the others and from the reset value. That lets the bench tell apart a live path, a stored path, a stale register and a wrongly cleared one. With eight-bit words it also reaches the simultaneous-load ordering case, where the B register must take the old A word, and the equal-value select switch.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W_DEF = 8;

  typedef enum logic {
    PATH_LIVE   = 1'b0,
    PATH_STORED = 1'b1
  } path_e;
endpackage

// File: rtl/xcvr_edge_store.sv
module xcvr_edge_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic ld_q;
  logic ld_rise;

  assign ld_rise = ld_i & ~ld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q <= 1'b0;
      q_o  <= '0;
    end else begin
      ld_q <= ld_i;
      if (ld_rise) q_o <= d_i;
    end
  end
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int unsigned W = 8
) (
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] y_o
);
  import xcvr_pkg::*;

  logic pick_st;
  assign pick_st = (sel_i == PATH_STORED);

  // consensus term keeps y steady when both sources agree
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_o[i] = (~pick_st & live_i[i]) | (pick_st & stored_i[i]) | (live_i[i] & stored_i[i]);
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int unsigned W = xcvr_pkg::XCVR_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ab_en_i,
  input  logic         ba_en_ni,
  input  logic         ab_sel_i,
  input  logic         ba_sel_i,
  input  logic         ab_ld_i,
  input  logic         ba_ld_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  logic         a_drv, b_drv;
  logic [W-1:0] a_q, b_q;
  logic [W-1:0] a_bus, b_bus;
  logic [W-1:0] a_bus_ext, b_bus_ext;

  assign b_drv = ab_en_i;
  assign a_drv = ~ba_en_ni;

  // one-sided bus views: the opposite side's live path uses its external input
  always_comb begin
    a_bus_ext = a_i;
    if (a_drv) a_bus_ext = ba_sel_i ? b_q : b_i;
    b_bus_ext = b_i;
    if (b_drv) b_bus_ext = ab_sel_i ? a_q : a_i;
  end

  // full bus views; both-live contention falls back to the external inputs
  always_comb begin
    a_bus = a_i;
    if (a_drv) a_bus = ba_sel_i ? b_q : b_bus_ext;
    b_bus = b_i;
    if (b_drv) b_bus = ab_sel_i ? a_q : a_bus_ext;
  end

  xcvr_edge_store #(.W(W)) u_a_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (ab_ld_i),
    .d_i   (a_bus),
    .q_o   (a_q)
  );

  xcvr_edge_store #(.W(W)) u_b_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (ba_ld_i),
    .d_i   (b_bus),
    .q_o   (b_q)
  );

  xcvr_path_mux #(.W(W)) u_to_b (
    .sel_i   (ab_sel_i),
    .live_i  (a_bus),
    .stored_i(a_q),
    .y_o     (b_o)
  );

  xcvr_path_mux #(.W(W)) u_to_a (
    .sel_i   (ba_sel_i),
    .live_i  (b_bus),
    .stored_i(b_q),
    .y_o     (a_o)
  );

  assign a_oe_o = {W{a_drv}};
  assign b_oe_o = {W{b_drv}};
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ab_en_i,
  input logic         ba_en_ni,
  input logic         ab_sel_i,
  input logic         ba_sel_i,
  input logic         ab_ld_i,
  input logic         ba_ld_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] a_o,
  input logic [W-1:0] b_o,
  input logic [W-1:0] a_oe_o,
  input logic [W-1:0] b_oe_o,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q,
  input logic [W-1:0] a_bus,
  input logic [W-1:0] b_bus
);
  // R1
  b_oe_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(b_oe_o) == (ab_en_i ? W : 0));

  // R3
  isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_en_i && ba_en_ni) |-> ($countones(a_oe_o) == 0 && $countones(b_oe_o) == 0));

  // R4
  stored_to_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_sel_i |-> (b_o == a_q));

  // R4
  stored_to_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_sel_i |-> (a_o == b_q));

  // R5
  a_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_ld_i && !$past(ab_ld_i)) |=> (a_q == $past(a_bus)));

  // R5
  a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ab_ld_i |=> $stable(a_q));

  // R5
  b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ba_ld_i |=> $stable(b_q));

  // R9
  contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_en_i && !ba_en_ni && !ab_sel_i && !ba_sel_i) |-> (a_o == b_i && b_o == a_i));

  // R10
  agree_to_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_q == b_bus) |-> (a_o == b_q));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ab_en_i (ab_en_i),
  .ba_en_ni(ba_en_ni),
  .ab_sel_i(ab_sel_i),
  .ba_sel_i(ba_sel_i),
  .ab_ld_i (ab_ld_i),
  .ba_ld_i (ba_ld_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .a_o     (a_o),
  .b_o     (b_o),
  .a_oe_o  (a_oe_o),
  .b_oe_o  (b_oe_o),
  .a_q     (a_q),
  .b_q     (b_q),
  .a_bus   (a_bus),
  .b_bus   (b_bus)
);

// File: tb/sim_bus_xcvr_reg.sv
`timescale 1ns/1ps
module sim_bus_xcvr_reg;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ab_en_i = 1'b0, ba_en_ni = 1'b1;
  logic         ab_sel_i = 1'b0, ba_sel_i = 1'b0;
  logic         ab_ld_i = 1'b0, ba_ld_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] a_o, a_oe_o, b_o, b_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string        req;
    logic [W-1:0] ea, eb, eaoe, eboe;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  bus_xcvr_reg #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .ab_en_i(ab_en_i), .ba_en_ni(ba_en_ni),
    .ab_sel_i(ab_sel_i), .ba_sel_i(ba_sel_i),
    .ab_ld_i(ab_ld_i), .ba_ld_i(ba_ld_i),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o),
    .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o)
  );

  // monitor: pop expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (a_o !== e.ea || b_o !== e.eb || a_oe_o !== e.eaoe || b_oe_o !== e.eboe) begin
        fails++;
        $display("FAIL %s: a_o=%h b_o=%h a_oe=%h b_oe=%h expected a_o=%h b_o=%h a_oe=%h b_oe=%h",
                 e.req, a_o, b_o, a_oe_o, b_oe_o, e.ea, e.eb, e.eaoe, e.eboe);
      end
    end
  end

  task automatic drive(input logic en_ab, input logic en_ba_n, input logic s_ab,
                       input logic s_ba, input logic [W-1:0] av, input logic [W-1:0] bv);
    @(posedge clk); #1;
    ab_en_i = en_ab; ba_en_ni = en_ba_n; ab_sel_i = s_ab; ba_sel_i = s_ba;
    a_i = av; b_i = bv;
  endtask

  task automatic expect_out(input string req, input logic [W-1:0] ea, input logic [W-1:0] eb,
                            input logic [W-1:0] eaoe, input logic [W-1:0] eboe);
    exp_t e;
    e.req = req; e.ea = ea; e.eb = eb; e.eaoe = eaoe; e.eboe = eboe;
    sb.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic pulse(input logic la, input logic lb);
    @(posedge clk); #1;
    ab_ld_i = la; ba_ld_i = lb;
    @(posedge clk); #1;
    ab_ld_i = 1'b0; ba_ld_i = 1'b0;
  endtask

  localparam logic [W-1:0] ON = '1, OFF = '0;

  initial begin
    // R7 / R3: reset with stored paths selected, isolated
    ab_sel_i = 1'b1; ba_sel_i = 1'b1; a_i = 8'h5A; b_i = 8'hC3;
    repeat (2) @(posedge clk);
    #1;
    expect_out("R7", 8'h00, 8'h00, OFF, OFF);
    @(posedge clk); #1 rst_ni = 1'b1;

    // R1 R4: live A to B
    drive(1, 1, 0, 0, 8'h3C, 8'h00);
    expect_out("R1", 8'h3C, 8'h3C, OFF, ON);

    // R2: live B to A
    drive(0, 0, 0, 0, 8'h00, 8'h96);
    expect_out("R2", 8'h96, 8'h96, ON, OFF);

    // R5 R3: load while isolated, outputs defined while not driving
    drive(0, 1, 0, 0, 8'h11, 8'hEE);
    pulse(1, 1);
    drive(0, 1, 1, 1, 8'h22, 8'h33);
    expect_out("R3", 8'hEE, 8'h11, OFF, OFF);

    // R5: strobe held high loads once
    @(posedge clk); #1 a_i = 8'h44; ab_ld_i = 1'b1;
    @(posedge clk); #1 a_i = 8'h55;
    @(posedge clk); #1 a_i = 8'h66;
    @(posedge clk); #1 ab_ld_i = 1'b0;
    expect_out("R5", 8'hEE, 8'h44, OFF, OFF);

    // R6: loopback, A word into both registers
    drive(1, 1, 0, 0, 8'h77, 8'h00);
    pulse(1, 1);
    drive(0, 1, 1, 1, 8'h00, 8'h00);
    expect_out("R6", 8'h77, 8'h77, OFF, OFF);

    drive(0, 1, 0, 0, 8'h00, 8'hEE);
    pulse(0, 1);
    drive(0, 1, 1, 1, 8'h00, 8'h00);
    expect_out("R5", 8'hEE, 8'h77, OFF, OFF);

    // R8: same-edge loads take pre-edge values
    drive(1, 1, 1, 0, 8'h12, 8'h00);
    pulse(1, 1);
    drive(0, 1, 1, 1, 8'h00, 8'h00);
    expect_out("R8", 8'h77, 8'h12, OFF, OFF);

    // R9: both driving, both live
    drive(1, 0, 0, 0, 8'hA1, 8'hB2);
    expect_out("R9", 8'hB2, 8'hA1, ON, ON);
    pulse(1, 1);
    drive(0, 1, 1, 1, 8'h00, 8'h00);
    expect_out("R9", 8'hB2, 8'hA1, OFF, OFF);

    // R6: both driving, B carries stored A, A follows B
    drive(1, 0, 1, 0, 8'hFF, 8'h00);
    expect_out("R6", 8'hA1, 8'hA1, ON, ON);
    pulse(0, 1);
    drive(0, 1, 1, 1, 8'h00, 8'h00);
    expect_out("R6", 8'hA1, 8'hA1, OFF, OFF);

    // R10: select switch with equal sources
    drive(0, 1, 0, 0, 8'h00, 8'hA1);
    expect_out("R10", 8'hA1, 8'h00, OFF, OFF);
    drive(0, 1, 0, 1, 8'h00, 8'hA1);
    expect_out("R10", 8'hA1, 8'h00, OFF, OFF);
    drive(0, 1, 0, 0, 8'h00, 8'hA1);
    expect_out("R10", 8'hA1, 8'h00, OFF, OFF);

    // R4: differing sources
    drive(0, 1, 0, 0, 8'h00, 8'h5C);
    expect_out("R4", 8'h5C, 8'h00, OFF, OFF);
    drive(0, 1, 0, 1, 8'h00, 8'h5C);
    expect_out("R4", 8'hA1, 8'h00, OFF, OFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule